// File: doc/BRIEF.md
# Interleaved Flash Page Dispatch Engine

This block turns one request for a run of page reads or page writes into a timed stream of page issues spread over a fixed set of flash units. Each page goes through three phases in order: a channel switch, a register transfer and a cell operation (program for writes, sense for reads). All three are modelled as clock-cycle counts. Pages go to the units in rotating order. Two issues are spaced by the channel-switch time, so one page's register transfer and cell phase overlap with the issues that follow it.

A unit accepts a new page only once its previous page is fully finished. A new pass over the units therefore stalls whenever one full page time is longer than a whole pass of channel switches. The request ends with a one-cycle done pulse. That pulse comes one full page time after the last page of the final, possibly partial, pass was issued.

The block is used as a timing model next to a flash controller or inside a storage emulator. It moves no data.

Top module: `flash_page_dispatch`

## Requirements
- R1: After reset, `unitBusy` is all zeros, `issueValid` is low and `done` is low.
- R2: When `start` is accepted, the delay set is latched. `opWrite`=1 selects the `wr*` inputs and `opWrite`=0 selects the `rd*` inputs. The page time P is the sum of the channel, register and cell counts of that set. A channel count of 0 is treated as 1.
- R3: Pages are issued to units in the order 0, 1, …, RHO-1, then back to 0. `issueUnit` carries the unit index in each cycle where `issueValid` is high.
- R4: The first issue comes in the cycle after the cycle in which `start` is sampled. Inside one pass, each later issue comes exactly C cycles after the previous one, where C is the effective channel count.
- R5: Page i (counting from 0) is issued in cycle 1 + floor(i/RHO)·max(RHO·C, P) + (i mod RHO)·C, counted from the start cycle. This means a new pass waits until unit 0's previous page has run for P cycles.
- R6: `unitBusy[u]` is high for the P cycles that follow an issue to unit u, and low otherwise.
- R7: `done` is a single-cycle pulse in cycle P+1 after the last issue. All `unitBusy` bits are low in that cycle.
- R8: A page count of 0 gives `done` in the cycle after the start cycle, with no issue.
- R9: `start` has no effect from the cycle after it is accepted up to and including the `done` cycle. Changes to the count, op or delay inputs during that time have no effect either.
- R10: When the page count is not a multiple of RHO, the last pass issues only the remaining pages, and R5 and R7 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request start, sampled when idle |
| opWrite | input | 1 | 1 = write delay set, 0 = read delay set |
| pageCount | input | CNT_W | Number of pages in the request |
| wrChanDly | input | DLY_W | Write channel-switch cycles |
| wrRegDly | input | DLY_W | Write register-transfer cycles |
| wrCellDly | input | DLY_W | Program cycles |
| rdChanDly | input | DLY_W | Read channel-switch cycles |
| rdRegDly | input | DLY_W | Read register-transfer cycles |
| rdCellDly | input | DLY_W | Cell sense cycles |
| unitBusy | output | RHO | Per-unit busy flags |
| issueValid | output | 1 | Issue strobe |
| issueUnit | output | UNIT_W | Unit index of the current issue |
| done | output | 1 | Request-complete pulse |

## Verification
Directed requests cover four cases:
- page times longer than a pass, which tests the stall between passes;
- page times shorter than a pass, which tests back-to-back passes;
- a zero channel count, which tests the clamp to one cycle;
- page counts of zero, one and non-multiples of the unit count.

Random requests mix both ops. The two delay sets are always given different values, so selecting the wrong set shows up as shifted issue and busy timing. Further requests pulse `start` with altered inputs, once in mid-request and once in the done cycle. A design that accepts either pulse produces extra issues or a second done.

// File: rtl/flash_dispatch_pkg.sv
package flash_dispatch_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch a new request
    logic issue;  // dispatch one page to the current unit
  } dispStrobe_t;
endpackage

// File: rtl/flash_dispatch_dp.sv
module flash_dispatch_dp
  import flash_dispatch_pkg::*;
#(
  parameter int RHO   = 4,
  parameter int DLY_W = 20,
  parameter int CNT_W = 16,
  localparam int UNIT_W = (RHO > 1) ? $clog2(RHO) : 1,
  localparam int PAGE_W = DLY_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dispStrobe_t       strobe,
  input  logic              opWrite,
  input  logic [CNT_W-1:0]  pageCount,
  input  logic [DLY_W-1:0]  wrChanDly,
  input  logic [DLY_W-1:0]  wrRegDly,
  input  logic [DLY_W-1:0]  wrCellDly,
  input  logic [DLY_W-1:0]  rdChanDly,
  input  logic [DLY_W-1:0]  rdRegDly,
  input  logic [DLY_W-1:0]  rdCellDly,
  output logic [RHO-1:0]    unitBusy,
  output logic [UNIT_W-1:0] unitPtr,
  output logic              issueReady,
  output logic              noPagesLeft,
  output logic              allIdle
);

  logic [DLY_W-1:0]  chEff, gapCnt;
  logic [PAGE_W-1:0] pageTime;
  logic [CNT_W-1:0]  remain;
  logic [PAGE_W-1:0] cntView [RHO];

  logic [DLY_W-1:0]  chRaw, chSel, regSel, cellSel;
  logic [PAGE_W-1:0] ptSel;
  logic              lastUnit;

  always_comb begin
    chRaw   = opWrite ? wrChanDly : rdChanDly;
    regSel  = opWrite ? wrRegDly  : rdRegDly;
    cellSel = opWrite ? wrCellDly : rdCellDly;
    chSel   = (chRaw == '0) ? DLY_W'(1) : chRaw;
    ptSel   = PAGE_W'(chSel) + PAGE_W'(regSel) + PAGE_W'(cellSel);
  end

  assign lastUnit = (unitPtr == UNIT_W'(RHO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chEff    <= '0;
      pageTime <= '0;
      gapCnt   <= '0;
      remain   <= '0;
      unitPtr  <= '0;
    end else if (strobe.load) begin
      chEff    <= chSel;
      pageTime <= ptSel;
      gapCnt   <= '0;
      remain   <= pageCount;
      unitPtr  <= '0;
    end else if (strobe.issue) begin
      gapCnt   <= chEff;
      remain   <= remain - 1'b1;
      unitPtr  <= lastUnit ? '0 : unitPtr + 1'b1;
    end else if (gapCnt != '0) begin
      gapCnt   <= gapCnt - 1'b1;
    end
  end

  // one page-time counter per flash unit
  for (genvar u = 0; u < RHO; u++) begin : g_unit
    logic [PAGE_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (strobe.issue && unitPtr == UNIT_W'(u))
        cnt <= pageTime;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
    assign cntView[u]  = cnt;
    assign unitBusy[u] = (cnt != '0);
  end

  // counter at 1 means the page finishes this cycle; the next may follow
  assign issueReady  = (gapCnt <= DLY_W'(1)) && (cntView[unitPtr] <= PAGE_W'(1));
  assign noPagesLeft = (remain == '0);
  assign allIdle     = ~|unitBusy;

  // R6: the unit just issued to reads busy in the following cycle
  assert_busy_after_issue_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.issue |=> unitBusy[$past(unitPtr)]);

  // R4: with a channel time above one cycle, issues never come back to back
  assert_issue_spacing_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.issue && chEff > DLY_W'(1)) |=> !strobe.issue);

endmodule

// File: rtl/flash_dispatch_ctl.sv
module flash_dispatch_ctl
  import flash_dispatch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        issueReady,
  input  logic        noPagesLeft,
  input  logic        allIdle,
  output dispStrobe_t strobe,
  output logic        done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;
  ctlState_t state;

  always_comb begin
    strobe.load  = (state == ST_IDLE) && start;
    strobe.issue = (state == ST_RUN) && !noPagesLeft && issueReady;
    done         = (state == ST_RUN) && noPagesLeft && allIdle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= ST_IDLE;
    else if (strobe.load)
      state <= ST_RUN;
    else if (done)
      state <= ST_IDLE;
  end

  // R9: a request is only taken while every unit is idle
  assert_load_when_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |-> allIdle);

endmodule

// File: rtl/flash_page_dispatch.sv
module flash_page_dispatch
  import flash_dispatch_pkg::*;
#(
  parameter int RHO   = 4,
  parameter int DLY_W = 20,
  parameter int CNT_W = 16,
  localparam int UNIT_W = (RHO > 1) ? $clog2(RHO) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              opWrite,
  input  logic [CNT_W-1:0]  pageCount,
  input  logic [DLY_W-1:0]  wrChanDly,
  input  logic [DLY_W-1:0]  wrRegDly,
  input  logic [DLY_W-1:0]  wrCellDly,
  input  logic [DLY_W-1:0]  rdChanDly,
  input  logic [DLY_W-1:0]  rdRegDly,
  input  logic [DLY_W-1:0]  rdCellDly,
  output logic [RHO-1:0]    unitBusy,
  output logic              issueValid,
  output logic [UNIT_W-1:0] issueUnit,
  output logic              done
);

  dispStrobe_t strobe;
  logic        issueReady, noPagesLeft, allIdle;

  flash_dispatch_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .issueReady(issueReady), .noPagesLeft(noPagesLeft), .allIdle(allIdle),
    .strobe(strobe), .done(done)
  );

  flash_dispatch_dp #(.RHO(RHO), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .opWrite(opWrite), .pageCount(pageCount),
    .wrChanDly(wrChanDly), .wrRegDly(wrRegDly), .wrCellDly(wrCellDly),
    .rdChanDly(rdChanDly), .rdRegDly(rdRegDly), .rdCellDly(rdCellDly),
    .unitBusy(unitBusy), .unitPtr(issueUnit),
    .issueReady(issueReady), .noPagesLeft(noPagesLeft), .allIdle(allIdle)
  );

  assign issueValid = strobe.issue;

  // R7: completion finds every unit idle
  assert_done_all_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (unitBusy == '0));

  // R7: completion lasts exactly one cycle
  assert_done_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/flash_page_dispatch_bench.sv
module flash_page_dispatch_bench;
  localparam int RHO = 4;
  localparam int DLY_W = 20;
  localparam int CNT_W = 16;
  localparam int UNIT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, opWrite = 1'b0;
  logic [CNT_W-1:0] pageCount = '0;
  logic [DLY_W-1:0] wrChanDly = '0, wrRegDly = '0, wrCellDly = '0;
  logic [DLY_W-1:0] rdChanDly = '0, rdRegDly = '0, rdCellDly = '0;
  logic [RHO-1:0] unitBusy;
  logic issueValid, done;
  logic [UNIT_W-1:0] issueUnit;

  int total = 0, bad = 0;

  flash_page_dispatch #(.RHO(RHO), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_flash_page_dispatch (
    .clk(clk), .rst_n(rst_n), .start(start), .opWrite(opWrite), .pageCount(pageCount),
    .wrChanDly(wrChanDly), .wrRegDly(wrRegDly), .wrCellDly(wrCellDly),
    .rdChanDly(rdChanDly), .rdRegDly(rdRegDly), .rdCellDly(rdCellDly),
    .unitBusy(unitBusy), .issueValid(issueValid), .issueUnit(issueUnit), .done(done)
  );

  always #4 clk = ~clk;

  // expected model from the requirements
  function automatic int effCh(int ch);
    return (ch == 0) ? 1 : ch;
  endfunction
  function automatic int issueT(int i, int c, int p);
    int s = (RHO * c > p) ? RHO * c : p;
    return 1 + (i / RHO) * s + (i % RHO) * c;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp, int k);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  task automatic runReq(bit wr, int n, int ch, int rg, int cl,
                        bit pokeMid, bit pokeDone, string tag);
    int c = effCh(ch);
    int p = c + rg + cl;
    int doneT = (n == 0) ? 1 : issueT(n - 1, c, p) + p + 1;
    opWrite = wr;
    pageCount = CNT_W'(n);
    // the unused set always differs from the selected one (R2)
    if (wr) begin
      wrChanDly = DLY_W'(ch); wrRegDly = DLY_W'(rg); wrCellDly = DLY_W'(cl);
      rdChanDly = DLY_W'(ch + 2); rdRegDly = DLY_W'(rg + 3); rdCellDly = DLY_W'(cl + 5);
    end else begin
      rdChanDly = DLY_W'(ch); rdRegDly = DLY_W'(rg); rdCellDly = DLY_W'(cl);
      wrChanDly = DLY_W'(ch + 2); wrRegDly = DLY_W'(rg + 3); wrCellDly = DLY_W'(cl + 5);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= doneT + 3; k++) begin
      bit expIss = 1'b0;
      int expUnit = 0;
      logic [RHO-1:0] expBusy = '0;
      for (int i = 0; i < n; i++) begin
        int t = issueT(i, c, p);
        if (t == k) begin expIss = 1'b1; expUnit = i % RHO; end
        if (t < k && k <= t + p) expBusy[i % RHO] = 1'b1;
      end
      check(issueValid == expIss, {tag, " R4 R5 issue timing"}, int'(issueValid), int'(expIss), k);
      if (expIss && issueValid)
        check(int'(issueUnit) == expUnit, {tag, " R3 issue unit"}, int'(issueUnit), expUnit, k);
      check(unitBusy == expBusy, {tag, " R6 busy"}, int'(unitBusy), int'(expBusy), k);
      check(done == (k == doneT), {tag, " R7 done"}, int'(done), int'(k == doneT), k);
      if (k == doneT) check(unitBusy == '0, {tag, " R7 idle at done"}, int'(unitBusy), 0, k);
      start = 1'b0;
      if ((pokeMid && k == 2 && doneT > 2) || (pokeDone && k == doneT)) begin
        start = 1'b1;
        opWrite = ~wr;
        pageCount = CNT_W'(n + 3);
        wrChanDly = DLY_W'(1); rdChanDly = DLY_W'(1);
        wrCellDly = DLY_W'(2); rdCellDly = DLY_W'(2);
      end
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(unitBusy == '0, "R1 busy", int'(unitBusy), 0, 0);
    check(issueValid == 1'b0, "R1 issue", int'(issueValid), 0, 0);
    check(done == 1'b0, "R1 done", int'(done), 0, 0);

    runReq(1'b1, 8, 3, 4, 20, 1'b0, 1'b0, "R5 stall write");
    runReq(1'b0, 9, 5, 2, 3, 1'b0, 1'b0, "R10 partial read no stall");
    runReq(1'b1, 0, 4, 4, 4, 1'b0, 1'b0, "R8 zero pages");
    runReq(1'b0, 0, 4, 4, 4, 1'b0, 1'b1, "R8 R9 zero pages poke");
    runReq(1'b0, 5, 0, 2, 9, 1'b0, 1'b0, "R2 chan zero");
    runReq(1'b1, 1, 2, 3, 6, 1'b0, 1'b0, "R7 single page");
    runReq(1'b1, 6, 2, 3, 15, 1'b1, 1'b0, "R9 mid start");
    runReq(1'b0, 7, 3, 1, 4, 1'b0, 1'b1, "R9 start at done");
    runReq(1'b0, 4, 1, 1, 1, 1'b0, 1'b0, "R4 unit chan");

    for (int r = 0; r < 30; r++) begin
      bit wr = 1'(($urandom % 2));
      int n  = int'($urandom % 21);
      int ch = int'($urandom % 6);
      int rg = int'($urandom % 7) + 1;
      int cl = wr ? int'($urandom % 40) + 1 : int'($urandom % 8) + 1;
      runReq(wr, n, ch, rg, cl, 1'($urandom % 2), 1'($urandom % 2), "R2 R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule